// File: doc/BRIEF.md
# Pin Event Aggregator

The block gathers up to 32 general-purpose input pins, arriving as two 16-pin ports, into a single interrupt line. Each port is split into a lower and an upper 8-pin half. A routing register sends one half into each of four 8-bit byte lanes. Lanes 0 and 2 may take only a lower half, and lanes 1 and 3 may take only an upper half. Each routed bit first passes through a two-flop synchroniser. It can then be inverted. It is sensed either as a rising edge or as a level.

Pending bits are collected in a request register. The request bits that the enable mask lets through are ORed into a registered interrupt output. Software uses a word-addressed 32-bit register bus to set up the block and to service requests. The enable, sense-mode and invert states each have a write-1-to-set address and a write-1-to-clear address. To sense both edges of a pin, software flips the invert bit after each event.

Top module: `pin_event_hub`

## Requirements
- R1: After reset, every register reads 0 and `irq_o` is 0.
- R2: Writing address 0 sets the enable-mask bits written as 1, and writing address 1 clears them. Bits written as 0 keep their value. Reading either address returns the mask.
- R3: The sense-mode state (1 = edge, 0 = level) is set through address 4 and cleared through address 5. The invert state is set through address 6 and cleared through address 7. Both follow the R2 write-1 rules. Each pair of addresses reads back the current state.
- R4: Address 3 holds one route bit per lane, at bit 8*k for lane k; reads return 0 in every other bit. Lanes 0 and 2 take pins[7:0] when their route bit is 0 and pins[23:16] when it is 1. Lanes 1 and 3 take pins[15:8] when their route bit is 0 and pins[31:24] when it is 1.
- R5: In edge mode, a 0-to-1 change of the conditioned bit (routed pin XOR invert) sets the request bit at address 2. The bit stays set until a 1 is written to it there. It does not set again while the input stays high.
- R6: Setting a bit's invert makes a falling pin raise a request. Changing the invert bit is itself a change of the conditioned value.
- R7: In level mode, the request bit equals the conditioned bit of the previous cycle. A write-1-to-clear has no effect on it while the input stays active.
- R8: An edge event in the same cycle as a write-1-to-clear of that request bit leaves the bit set.
- R9: `irq_o` is a register that, one cycle later, shows the OR of request AND mask over all 32 bits.
- R10: A pin change reaches the request register on the third rising clock edge after it is applied: two synchroniser stages, then the request register.
- R11: Addresses 8 to 15 read 0. Writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pins_i | input | 32 | Raw pins: port 0 on [15:0], port 1 on [31:16] |
| addr_i | input | 4 | Register word address |
| we_i | input | 1 | Write strobe |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i (combinational) |
| irq_o | output | 1 | Aggregated interrupt |

## Verification
Routing is tried with the second port's lower half steered into lane 2, using a nonsymmetric pattern (0x5A), so that a wrong half or a wrong lane shows up as a wrong bit pattern. Edge sensing is driven with rising pins, falling pins under invert, and a toggle of the invert bit itself. Together these separate "event on a conditioned change" from "event on a pin change". Level mode is driven with a held active input while clears are written. The clear-versus-event collision is timed so that the write lands on the exact edge on which the synchronised rise arrives.

// File: rtl/pin_event_pkg.sv
package pin_event_pkg;

    localparam int LANE_W    = 8;
    localparam int NUM_LANES = 4;
    localparam int NUM_PINS  = LANE_W * NUM_LANES;
    localparam int PORT_W    = 2 * LANE_W;
    localparam int DATA_W    = 32;
    localparam int ADDR_W    = 4;

    localparam logic [ADDR_W-1:0] A_MASK_SET = 4'd0;
    localparam logic [ADDR_W-1:0] A_MASK_CLR = 4'd1;
    localparam logic [ADDR_W-1:0] A_REQ      = 4'd2;
    localparam logic [ADDR_W-1:0] A_ROUTE    = 4'd3;
    localparam logic [ADDR_W-1:0] A_EDGE_SET = 4'd4;
    localparam logic [ADDR_W-1:0] A_EDGE_CLR = 4'd5;
    localparam logic [ADDR_W-1:0] A_INV_SET  = 4'd6;
    localparam logic [ADDR_W-1:0] A_INV_CLR  = 4'd7;

    typedef struct packed {
        logic [NUM_PINS-1:0]  mask;
        logic [NUM_PINS-1:0]  sense_edge;
        logic [NUM_PINS-1:0]  inv;
        logic [NUM_PINS-1:0]  req;
        logic [NUM_PINS-1:0]  prev;
        logic [NUM_LANES-1:0] route;
        logic                 irq;
    } hub_state_t;

endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
    parameter int W = 32
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] s1_d, s1_q, s2_d, s2_q;

    always_comb begin
        s1_d = d_i;
        s2_d = s1_q;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s1_q <= '0;
            s2_q <= '0;
        end else begin
            s1_q <= s1_d;
            s2_q <= s2_d;
        end
    end

    assign q_o = s2_q;
endmodule

// File: rtl/lane_router.sv
module lane_router #(
    parameter int LANE_W    = 8,
    parameter int NUM_LANES = 4
) (
    input  logic [4*LANE_W-1:0]         pins_i,
    input  logic [NUM_LANES-1:0]        route_i,
    output logic [NUM_LANES*LANE_W-1:0] lanes_o
);
    localparam int PORT_W = 2 * LANE_W;

    for (genvar k = 0; k < NUM_LANES; k++) begin : g_lane
        localparam int HALF = k % 2;
        assign lanes_o[k*LANE_W +: LANE_W] = route_i[k]
            ? pins_i[PORT_W + HALF*LANE_W +: LANE_W]
            : pins_i[HALF*LANE_W +: LANE_W];
    end
endmodule

// File: rtl/req_update.sv
module req_update #(
    parameter int W = 32
) (
    input  logic [W-1:0] cond_i,
    input  logic [W-1:0] prev_i,
    input  logic [W-1:0] sense_edge_i,
    input  logic [W-1:0] req_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] req_o
);
    logic [W-1:0] rise;
    logic [W-1:0] edge_next;

    always_comb begin
        rise      = cond_i & ~prev_i;
        edge_next = (req_i & ~clr_i) | rise;
        req_o     = (sense_edge_i & edge_next) | (~sense_edge_i & cond_i);
    end
endmodule

// File: rtl/pin_event_hub.sv
module pin_event_hub
    import pin_event_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [31:0]       pins_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              we_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              irq_o
);
    hub_state_t st_d, st_q;

    logic [NUM_PINS-1:0] synced;
    logic [NUM_PINS-1:0] lanes;
    logic [NUM_PINS-1:0] cond;
    logic [NUM_PINS-1:0] clr_req;
    logic [NUM_PINS-1:0] req_next;
    logic [DATA_W-1:0]   route_rd;

    pin_sync #(.W(NUM_PINS)) i_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .d_i    (pins_i),
        .q_o    (synced)
    );

    lane_router #(.LANE_W(LANE_W), .NUM_LANES(NUM_LANES)) i_router (
        .pins_i  (synced),
        .route_i (st_q.route),
        .lanes_o (lanes)
    );

    assign cond    = lanes ^ st_q.inv;
    assign clr_req = (we_i && addr_i == A_REQ) ? wdata_i : '0;

    req_update #(.W(NUM_PINS)) i_req (
        .cond_i       (cond),
        .prev_i       (st_q.prev),
        .sense_edge_i (st_q.sense_edge),
        .req_i        (st_q.req),
        .clr_i        (clr_req),
        .req_o        (req_next)
    );

    always_comb begin
        route_rd = '0;
        for (int k = 0; k < NUM_LANES; k++) begin
            route_rd[k*LANE_W] = st_q.route[k];
        end
    end

    always_comb begin
        st_d      = st_q;
        st_d.prev = cond;
        st_d.req  = req_next;
        st_d.irq  = |(st_q.req & st_q.mask);
        if (we_i) begin
            case (addr_i)
                A_MASK_SET: st_d.mask       = st_q.mask | wdata_i;
                A_MASK_CLR: st_d.mask       = st_q.mask & ~wdata_i;
                A_EDGE_SET: st_d.sense_edge = st_q.sense_edge | wdata_i;
                A_EDGE_CLR: st_d.sense_edge = st_q.sense_edge & ~wdata_i;
                A_INV_SET:  st_d.inv        = st_q.inv | wdata_i;
                A_INV_CLR:  st_d.inv        = st_q.inv & ~wdata_i;
                A_ROUTE: begin
                    for (int k = 0; k < NUM_LANES; k++) begin
                        st_d.route[k] = wdata_i[k*LANE_W];
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    always_comb begin
        case (addr_i)
            A_MASK_SET, A_MASK_CLR: rdata_o = st_q.mask;
            A_EDGE_SET, A_EDGE_CLR: rdata_o = st_q.sense_edge;
            A_INV_SET,  A_INV_CLR:  rdata_o = st_q.inv;
            A_REQ:                  rdata_o = st_q.req;
            A_ROUTE:                rdata_o = route_rd;
            default:                rdata_o = '0;
        endcase
    end

    assign irq_o = st_q.irq;

    logic [NUM_PINS-1:0] edge_event;
    assign edge_event = st_q.sense_edge & cond & ~st_q.prev;

    // R2
    mask_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (we_i && addr_i == A_MASK_SET) |=> ((st_q.mask & $past(wdata_i)) == $past(wdata_i)));

    // R3
    inv_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (we_i && addr_i == A_INV_CLR) |=> ((st_q.inv & $past(wdata_i)) == '0));

    // R7
    level_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> ((st_q.req & ~$past(st_q.sense_edge)) == ($past(cond) & ~$past(st_q.sense_edge))));

    // R8
    event_kept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> ((st_q.req & $past(edge_event)) == $past(edge_event)));

    // R9
    irq_reg_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> (irq_o == $past(|(st_q.req & st_q.mask))));
endmodule

// File: tb/test_pin_event_hub.sv
module test_pin_event_hub;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] pins = '0;
    logic [3:0]  addr = '0;
    logic        we = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    pin_event_hub i_pin_event_hub (
        .clk_i(clk), .rst_ni(rst_n), .pins_i(pins), .addr_i(addr),
        .we_i(we), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
    );

    // behavioural reference
    logic [31:0] m_s1, m_s2, m_prev, m_req, m_mask, m_edge, m_inv;
    logic [3:0]  m_route;
    logic        m_irq;
    logic [31:0] m_cond, m_nreq, m_clr;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_s1 = 0; m_s2 = 0; m_prev = 0; m_req = 0; m_mask = 0;
            m_edge = 0; m_inv = 0; m_route = 0; m_irq = 0;
        end else begin
            for (int i = 0; i < 32; i++) begin
                int lane, src;
                lane = i / 8;
                src = (m_route[lane] ? 16 : 0) + (lane % 2) * 8 + (i % 8);
                m_cond[i] = m_s2[src] ^ m_inv[i];
            end
            m_clr = (we && addr == 4'd2) ? wdata : 32'h0;
            for (int i = 0; i < 32; i++) begin
                if (m_edge[i]) m_nreq[i] = (m_req[i] && !m_clr[i]) || (m_cond[i] && !m_prev[i]);
                else           m_nreq[i] = m_cond[i];
            end
            m_irq = |(m_req & m_mask);
            if (we) begin
                case (addr)
                    4'd0: m_mask = m_mask | wdata;
                    4'd1: m_mask = m_mask & ~wdata;
                    4'd3: m_route = {wdata[24], wdata[16], wdata[8], wdata[0]};
                    4'd4: m_edge = m_edge | wdata;
                    4'd5: m_edge = m_edge & ~wdata;
                    4'd6: m_inv = m_inv | wdata;
                    4'd7: m_inv = m_inv & ~wdata;
                    default: ;
                endcase
            end
            m_prev = m_cond;
            m_req  = m_nreq;
            m_s2   = m_s1;
            m_s1   = pins;
        end
    end

    function automatic logic [31:0] model_rd(input logic [3:0] a);
        case (a)
            4'd0, 4'd1: return m_mask;
            4'd2:       return m_req;
            4'd3:       return {7'd0, m_route[3], 7'd0, m_route[2], 7'd0, m_route[1], 7'd0, m_route[0]};
            4'd4, 4'd5: return m_edge;
            4'd6, 4'd7: return m_inv;
            default:    return 32'h0;
        endcase
    endfunction

    function automatic string tag_of(input logic [3:0] a);
        case (a)
            4'd0, 4'd1: return "R2";
            4'd2:       return "R5";
            4'd3:       return "R4";
            4'd4, 4'd5, 4'd6, 4'd7: return "R3";
            default:    return "R11";
        endcase
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic cyc();
        @(negedge clk);
        if (rst_n) begin
            chk(tag_of(addr), rdata, model_rd(addr));
            chk("R9", {31'd0, irq}, {31'd0, m_irq});
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        addr = a; we = 1'b1; wdata = d;
        cyc();
        we = 1'b0; wdata = '0;
    endtask

    task automatic rd(input logic [3:0] a, input logic [31:0] exp, input string tag);
        addr = a; we = 1'b0;
        #1;
        chk(tag, rdata, exp);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state, R11 unmapped reads
        for (int a = 0; a < 10; a++) rd(a[3:0], 32'h0, (a < 8) ? "R1" : "R11");
        chk("R1", {31'd0, irq}, 32'h0);
        cyc();
        // R2 mask aliases
        wr(4'd0, 32'h0000_00F0);
        wr(4'd0, 32'h0F00_0000);
        wr(4'd1, 32'h0000_0030);
        rd(4'd1, 32'h0F00_00C0, "R2");
        rd(4'd0, 32'h0F00_00C0, "R2");
        // R3 edge and invert aliases
        wr(4'd4, 32'hFFFF_FFFF);
        rd(4'd5, 32'hFFFF_FFFF, "R3");
        wr(4'd6, 32'h0000_FF00);
        wr(4'd7, 32'h0000_0F00);
        rd(4'd6, 32'h0000_F000, "R3");
        wr(4'd7, 32'hFFFF_FFFF);
        cyc();
        wr(4'd2, 32'hFFFF_FFFF);
        rd(4'd2, 32'h0, "R5");
        // R4 routing, R10 latency
        wr(4'd3, 32'h0101_0000);
        rd(4'd3, 32'h0101_0000, "R4");
        pins = 32'h005A_0000;
        rd(4'd2, 32'h0, "R10");
        cyc(); cyc();
        rd(4'd2, 32'h0, "R10");
        cyc();
        rd(4'd2, 32'h005A_0000, "R4");
        // R5 held input does not re-trigger
        wr(4'd2, 32'h005A_0000);
        cyc();
        rd(4'd2, 32'h0, "R5");
        // R6 invert toggle and falling pins
        wr(4'd6, 32'h00FF_0000);
        cyc();
        rd(4'd2, 32'h00A5_0000, "R6");
        wr(4'd2, 32'hFFFF_FFFF);
        pins = 32'h0;
        cyc(); cyc(); cyc();
        rd(4'd2, 32'h005A_0000, "R6");
        // R7 level mode
        wr(4'd5, 32'h00FF_0000);
        cyc();
        rd(4'd2, 32'h00FF_0000, "R7");
        wr(4'd2, 32'hFFFF_FFFF);
        rd(4'd2, 32'h00FF_0000, "R7");
        wr(4'd7, 32'h00FF_0000);
        cyc();
        rd(4'd2, 32'h0, "R7");
        // R8 event beats clear
        wr(4'd4, 32'h00FF_0000);
        pins = 32'h0001_0000;
        cyc(); cyc(); cyc();
        rd(4'd2, 32'h0001_0000, "R8");
        pins = 32'h0;
        cyc(); cyc(); cyc();
        pins = 32'h0001_0000;
        cyc(); cyc();
        wr(4'd2, 32'h0001_0000);
        rd(4'd2, 32'h0001_0000, "R8");
        // R9 registered interrupt
        wr(4'd0, 32'h0001_0000);
        chk("R9", {31'd0, irq}, 32'h0);
        cyc();
        chk("R9", {31'd0, irq}, 32'h1);
        wr(4'd2, 32'h0001_0000);
        chk("R9", {31'd0, irq}, 32'h1);
        cyc();
        chk("R9", {31'd0, irq}, 32'h0);
        // R11 unmapped writes
        wr(4'd9, 32'hFFFF_FFFF);
        rd(4'd9, 32'h0, "R11");
        rd(4'd0, 32'h0F01_00C0, "R11");
        rd(4'd6, 32'h0, "R11");
        rd(4'd3, 32'h0101_0000, "R11");
        cyc(); cyc();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 20);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule